// File: doc/BRIEF.md
# Variable-Length Instruction Fetch Decoder

This block sits right after instruction fetch in a simple sequential processor. Each cycle it takes the program counter and the six bytes of instruction memory that start at that address. The first byte gives the operation class and its function code. The opcode then decides whether a register-specifier byte follows and whether a 4-byte constant follows. An encoding is therefore 1, 2, 5 or 6 bytes long.

The block separates out the register specifiers and the constant. It fills in neutral defaults for any field that is absent. It flags opcodes it does not recognise, reports which optional fields were found and computes the address of the next sequential instruction. The block has no storage of its own and does not execute anything. Its results are registered once, so a decode appears one clock after the inputs are sampled.

Top module: `fdec_top`

## Requirements
- R1: The register stage has a synchronous, active-high reset. While reset is asserted at a clock edge, the outputs after that edge are: op_o=0, fn_o=0, ra_o=8, rb_o=8, const_o=0, next_pc_o=0, legal_o=0, has_reg_o=0 and has_const_o=0.
- R2: Byte k of `code_i` (bits 8k+7..8k) is the byte at address pc_i+k. The outputs after each clock edge describe the pc_i and code_i sampled at that edge. op_o is bits 7..4 of byte 0 and fn_o is bits 3..0 of byte 0.
- R3: legal_o is 1 exactly when op_o is in the range 0x0 to 0xB. For any opcode from 0xC to 0xF, has_reg_o=0, has_const_o=0 and next_pc_o=pc+1.
- R4: has_reg_o is 1 exactly for opcodes 0x2, 0x3, 0x4, 0x5, 0x6, 0xA and 0xB. When it is 1, ra_o is bits 7..4 of byte 1 and rb_o is bits 3..0 of byte 1.
- R5: has_const_o is 1 exactly for opcodes 0x3, 0x4, 0x5, 0x7 and 0x8. The constant is little-endian, so the lowest-addressed byte is the least significant. It starts at byte 1 when there is no register byte (0x7, 0x8) and at byte 2 otherwise.
- R6: When there is no register byte, ra_o and rb_o are both 8 ("no register"), whatever the value of byte 1.
- R7: When there is no constant, const_o is 0, whatever the values of the later bytes.
- R8: next_pc_o = pc + 1 + has_reg + 4·has_const, modulo 2^32. This gives lengths of 1, 2, 5 or 6 bytes, and the sum wraps past 0xFFFFFFFF.
- R9: The function nibble does not change legality, field presence, the constant's position or next_pc_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pc_i | input | 32 | Address of the first instruction byte |
| code_i | input | 48 | Six fetched bytes, byte k at bits 8k+7..8k |
| op_o | output | 4 | Operation class nibble |
| fn_o | output | 4 | Function nibble |
| ra_o | output | 4 | First register specifier, 8 if none |
| rb_o | output | 4 | Second register specifier, 8 if none |
| const_o | output | 32 | Constant word, 0 if none |
| next_pc_o | output | 32 | Address of the next sequential instruction |
| legal_o | output | 1 | Opcode recognised |
| has_reg_o | output | 1 | Register byte present |
| has_const_o | output | 1 | Constant word present |

## Verification
Two results are produced together in one decode, and both depend on the same register-byte decision. One is the selection of the constant, whose starting byte moves. The other is the next-address sum, which adds a term for that byte. Opcodes that carry both a register byte and a constant are combined with program counters near 0xFFFFFFFF. Each such case is judged by comparing the constant, both specifiers and the wrapped next address against a reference model in the bench. Random byte patterns behind every opcode also check that the defaults ignore unused bytes.

// File: rtl/fdec_pkg.sv
package fdec_pkg;
  typedef enum logic [3:0] {
    OP_NOP   = 4'h0,
    OP_HALT  = 4'h1,
    OP_RMOV  = 4'h2,
    OP_IMOV  = 4'h3,
    OP_STORE = 4'h4,
    OP_LOAD  = 4'h5,
    OP_ALU   = 4'h6,
    OP_JUMP  = 4'h7,
    OP_CALL  = 4'h8,
    OP_RET   = 4'h9,
    OP_PUSH  = 4'hA,
    OP_POP   = 4'hB
  } op_e;

  localparam logic [3:0] REG_NONE = 4'h8;
  localparam logic [3:0] OP_LAST  = 4'hB;
endpackage

// File: rtl/fdec_class.sv
module fdec_class
  import fdec_pkg::*;
(
  input  logic [3:0] op,
  output logic       legal,
  output logic       has_reg,
  output logic       has_const
);
  always_comb begin
    legal     = (op <= OP_LAST);
    has_reg   = 1'b0;
    has_const = 1'b0;
    case (op)
      OP_RMOV, OP_ALU, OP_PUSH, OP_POP: has_reg = 1'b1;
      OP_IMOV, OP_STORE, OP_LOAD: begin
        has_reg   = 1'b1;
        has_const = 1'b1;
      end
      OP_JUMP, OP_CALL: has_const = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/fdec_align.sv
module fdec_align
  import fdec_pkg::*;
#(
  parameter int WORD_BYTES = 4,
  localparam int TAIL_BYTES = WORD_BYTES + 1,
  localparam int WORD_W = 8 * WORD_BYTES
) (
  input  logic [8*TAIL_BYTES-1:0] tail,
  input  logic                    has_reg,
  input  logic                    has_const,
  output logic [3:0]              ra,
  output logic [3:0]              rb,
  output logic [WORD_W-1:0]       word
);
  logic [WORD_W-1:0] picked;

  for (genvar k = 0; k < WORD_BYTES; k++) begin : g_byte
    assign picked[8*k +: 8] = has_reg ? tail[8*(k+1) +: 8] : tail[8*k +: 8];
  end

  assign ra   = has_reg ? tail[7:4] : REG_NONE;
  assign rb   = has_reg ? tail[3:0] : REG_NONE;
  assign word = has_const ? picked : '0;
endmodule

// File: rtl/fdec_nextpc.sv
module fdec_nextpc #(
  parameter int ADDR_W = 32,
  parameter int WORD_BYTES = 4
) (
  input  logic [ADDR_W-1:0] pc,
  input  logic              has_reg,
  input  logic              has_const,
  output logic [ADDR_W-1:0] next_pc
);
  localparam logic [ADDR_W-1:0] WORD_STEP = ADDR_W'(WORD_BYTES);

  always_comb begin
    next_pc = pc + ADDR_W'(1) + ADDR_W'(has_reg) + (has_const ? WORD_STEP : '0);
  end
endmodule

// File: rtl/fdec_top.sv
module fdec_top
  import fdec_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int WORD_BYTES = 4,
  localparam int FETCH_BYTES = WORD_BYTES + 2,
  localparam int WORD_W = 8 * WORD_BYTES
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [ADDR_W-1:0]        pc_i,
  input  logic [8*FETCH_BYTES-1:0] code_i,
  output logic [3:0]               op_o,
  output logic [3:0]               fn_o,
  output logic [3:0]               ra_o,
  output logic [3:0]               rb_o,
  output logic [WORD_W-1:0]        const_o,
  output logic [ADDR_W-1:0]        next_pc_o,
  output logic                     legal_o,
  output logic                     has_reg_o,
  output logic                     has_const_o
);
  logic              c_legal, c_reg, c_const;
  logic [3:0]        c_ra, c_rb;
  logic [WORD_W-1:0] c_word;
  logic [ADDR_W-1:0] c_next;

  fdec_class u_class (
    .op(code_i[7:4]), .legal(c_legal), .has_reg(c_reg), .has_const(c_const)
  );

  fdec_align #(.WORD_BYTES(WORD_BYTES)) u_align (
    .tail(code_i[8*FETCH_BYTES-1:8]), .has_reg(c_reg), .has_const(c_const),
    .ra(c_ra), .rb(c_rb), .word(c_word)
  );

  fdec_nextpc #(.ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES)) u_next (
    .pc(pc_i), .has_reg(c_reg), .has_const(c_const), .next_pc(c_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      op_o <= '0; fn_o <= '0;
      ra_o <= REG_NONE; rb_o <= REG_NONE;
      const_o <= '0; next_pc_o <= '0;
      legal_o <= 1'b0; has_reg_o <= 1'b0; has_const_o <= 1'b0;
    end else begin
      op_o <= code_i[7:4]; fn_o <= code_i[3:0];
      ra_o <= c_ra; rb_o <= c_rb;
      const_o <= c_word; next_pc_o <= c_next;
      legal_o <= c_legal; has_reg_o <= c_reg; has_const_o <= c_const;
    end
  end

  a_r3_illegal_bare: assert property (@(posedge clk) disable iff (rst)
    !legal_o |-> (!has_reg_o && !has_const_o));
  a_r3_legal_range: assert property (@(posedge clk) disable iff (rst)
    legal_o |-> (op_o <= OP_LAST));
  a_r6_reg_default: assert property (@(posedge clk) disable iff (rst)
    !has_reg_o |-> (ra_o == REG_NONE && rb_o == REG_NONE));
  a_r7_const_zero: assert property (@(posedge clk) disable iff (rst)
    !has_const_o |-> (const_o == '0));
  a_r4_reg_from_byte1: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && has_reg_o) |-> (ra_o == $past(code_i[15:12]) && rb_o == $past(code_i[11:8])));
  a_r8_step: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (next_pc_o - $past(pc_i) ==
      ADDR_W'(1) + ADDR_W'(has_reg_o) + (has_const_o ? ADDR_W'(WORD_BYTES) : '0)));
endmodule

// File: tb/sim_fdec_top.sv
module sim_fdec_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] pc_i = '0;
  logic [47:0] code_i = '0;
  logic [3:0]  op_o, fn_o, ra_o, rb_o;
  logic [31:0] const_o, next_pc_o;
  logic        legal_o, has_reg_o, has_const_o;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  fdec_top u0 (
    .clk(clk), .rst(rst), .pc_i(pc_i), .code_i(code_i),
    .op_o(op_o), .fn_o(fn_o), .ra_o(ra_o), .rb_o(rb_o),
    .const_o(const_o), .next_pc_o(next_pc_o),
    .legal_o(legal_o), .has_reg_o(has_reg_o), .has_const_o(has_const_o)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit m_reg(logic [3:0] op);
    return op inside {4'h2, 4'h3, 4'h4, 4'h5, 4'h6, 4'hA, 4'hB};
  endfunction

  function automatic bit m_const(logic [3:0] op);
    return op inside {4'h3, 4'h4, 4'h5, 4'h7, 4'h8};
  endfunction

  task automatic apply_and_check(logic [31:0] pc, logic [47:0] code);
    logic [3:0] op;
    bit r, c;
    logic [31:0] k, np;
    op = code[7:4];
    r  = m_reg(op);
    c  = m_const(op);
    k  = !c ? 32'h0 : (r ? code[47:16] : code[39:8]);
    np = pc + 32'd1 + (r ? 32'd1 : 32'd0) + (c ? 32'd4 : 32'd0);
    @(negedge clk);
    pc_i = pc; code_i = code;
    @(negedge clk);
    check("R2 op", {28'h0, op_o}, {28'h0, op});
    check("R2 fn", {28'h0, fn_o}, {28'h0, code[3:0]});
    check("R3 legal", {31'h0, legal_o}, {31'h0, op <= 4'hB});
    check("R4 has_reg", {31'h0, has_reg_o}, {31'h0, r});
    check("R5 has_const", {31'h0, has_const_o}, {31'h0, c});
    check("R4/R6 ra", {28'h0, ra_o}, {28'h0, r ? code[15:12] : 4'h8});
    check("R4/R6 rb", {28'h0, rb_o}, {28'h0, r ? code[11:8] : 4'h8});
    check("R5/R7 const", const_o, k);
    check("R8 next_pc", next_pc_o, np);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'd1234);
    code_i = 48'hFFFF_FFFF_FFFF; pc_i = 32'hDEAD_BEEF;
    repeat (3) @(negedge clk);
    // R1: reset values
    check("R1 op", {28'h0, op_o}, 32'h0);
    check("R1 ra", {28'h0, ra_o}, 32'h8);
    check("R1 rb", {28'h0, rb_o}, 32'h8);
    check("R1 const", const_o, 32'h0);
    check("R1 next_pc", next_pc_o, 32'h0);
    check("R1 flags", {29'h0, legal_o, has_reg_o, has_const_o}, 32'h0);
    rst = 1'b0;
    // every opcode with a fixed pattern, R3 covers 0xC..0xF
    for (int op = 0; op < 16; op++)
      apply_and_check(32'h0000_1000, {40'h66_55_44_33_29, 4'(op), 4'h5});
    // R9: function nibble has no effect on layout
    for (int f = 0; f < 16; f++)
      apply_and_check(32'h40, {40'hA1_B2_C3_D4_E5, 4'h7, 4'(f)});
    // R8: wrap past the top of the address space with a 6-byte encoding
    apply_and_check(32'hFFFF_FFFC, 48'h12_34_56_78_9A_50);
    apply_and_check(32'hFFFF_FFFF, 48'h00_00_00_00_00_90);
    apply_and_check(32'hFFFF_FFFE, 48'hEF_BE_AD_DE_F1_80);
    // R6, R7: unused bytes all ones behind nop/halt/ret
    apply_and_check(32'h10, 48'hFFFF_FFFF_FF00);
    apply_and_check(32'h10, 48'hFFFF_FFFF_FF90);
    // constrained random: mostly legal opcodes
    for (int i = 0; i < 400; i++) begin
      logic [47:0] cw;
      cw = {$urandom(), $urandom()};
      if ($urandom_range(0, 7) != 0) cw[7:4] = 4'($urandom_range(0, 11));
      apply_and_check($urandom(), cw);
    end
    // R1: reset mid-stream
    @(negedge clk); rst = 1'b1; code_i = 48'h11_22_33_44_55_30;
    @(negedge clk);
    check("R1 flags again", {29'h0, legal_o, has_reg_o, has_const_o}, 32'h0);
    check("R1 const again", const_o, 32'h0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule